// File: doc/BRIEF.md
# Grouped Pin Change Interrupt Controller

This block watches twelve external input lines and raises an interrupt request when any enabled line changes level. The lines are split into two groups: group 0 holds lines 0 to 7 and group 1 holds lines 8 to 11. Each line can be enabled on its own through a per-group mask register. However, all lines of a group share a single pending flag and a single request output. Rising and falling transitions are treated alike.

Inputs pass through a two-flop synchronizer. A transition is found by comparing the synchronized value with a one-cycle-delayed copy of it. A group request is driven while the group's flag, the group's enable bit and the global interrupt enable input are all high. The pending flag clears in two ways: the interrupt controller pulses the group's acknowledge when the handler runs, or software writes a one to the flag's bit. A transition that arrives in the same cycle as either clear takes precedence, so the event is not lost.

Registers are written through a simple single-cycle write port and read through a combinational read port. The register map is:
- address 0: group 0 mask
- address 1: group 1 mask
- address 2: control, bit g enables group g
- address 3: flag, bit g is group g's pending flag

Top module: `pcint_ctrl`

## Requirements
- R1: A rising or falling transition on a line whose mask bit is 1 sets the flag of that line's group.
- R2: A transition on a line whose mask bit is 0 never sets its group flag.
- R3: irq[g] is 1 only while flag bit g, control bit g and the gie input are all 1.
- R4: A one-cycle pulse on ack[g] clears flag bit g at the next clock edge.
- R5: Writing address 3 with data bit g = 1 clears flag g; writing 0 to a flag bit leaves it unchanged.
- R6: After reset, both masks, the control register and the flag register read 0, and irq is 0.
- R7: Group 0 mask (address 0) bits 7:0 enable lines 7:0. Group 1 mask (address 1) bits 3:0 enable lines 11:8. Bits 7:4 of the group 1 mask ignore writes and read as 0.
- R8: If a qualifying transition is detected in the same cycle as a write-one clear or an acknowledge, the flag stays 1.
- R9: A line change that is stable before rising edge k is seen at the flag register after edge k+2 and not before, because of the two synchronizer stages plus the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 12 | Asynchronous input lines, bit n is line n |
| gie | input | 1 | Global interrupt enable |
| ack | input | 2 | Per-group acknowledge from the interrupt controller |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| irq | output | 2 | Per-group interrupt request |

## Verification
The bench drives both rising and falling transitions. A design that only detected one direction would leave the flag clear on the other. It toggles lines whose mask bit is off next to lines whose mask bit is on; a mask applied to the wrong group or bit would set the wrong flag. It lands a write-one clear and an acknowledge in exactly the cycle where a new transition is detected; a design that gave the clear priority would drop that event. It also probes the flag one cycle before and at the expected latency, so an extra or missing synchronizer stage shows up. Finally, it writes zeros to pending flags and ones to the unused mask bits, so that a design that let these writes through would be caught.

// File: rtl/pcint_pkg.sv
package pcint_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;
  localparam int NUM_GROUPS = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_MASK0 = 2'd0,
    ADR_MASK1 = 2'd1,
    ADR_CTRL  = 2'd2,
    ADR_FLAG  = 2'd3
  } reg_addr_e;

  // A line has changed when its synchronized value differs from the delayed copy.
  function automatic logic line_changed(logic now_v, logic prev_v);
    return now_v ^ prev_v;
  endfunction

  // Next flag state: a new hit wins over any clear request.
  function automatic logic flag_next(logic cur, logic hit, logic clr);
    return hit | (cur & ~clr);
  endfunction

  // Request gating: flag, group enable and global enable must all be set.
  function automatic logic req_gate(logic flag, logic en, logic glob);
    return flag & en & glob;
  endfunction

endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] chg_o
);
  import pcint_pkg::*;

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign chg_o[i] = line_changed(sync_q[i], prev_q[i]);
  end

endmodule

// File: rtl/pcint_group.sv
module pcint_group #(
  parameter int PINS  = 8,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PINS-1:0]  chg_i,
  input  logic             mask_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             clr_wr_i,
  input  logic             ack_i,
  output logic [REG_W-1:0] mask_o,
  output logic             flag_o,
  output logic             hit_o
);
  import pcint_pkg::*;

  logic [PINS-1:0] mask_q;
  logic            flag_q;
  logic            clr_any;

  assign hit_o   = |(chg_i & mask_q);
  assign clr_any = clr_wr_i | ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= wdata_i[PINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, hit_o, clr_any);
    end
  end

  assign flag_o = flag_q;

  if (PINS < REG_W) begin : g_pad
    assign mask_o = {{(REG_W-PINS){1'b0}}, mask_q};
  end else begin : g_full
    assign mask_o = mask_q;
  end

  // R1: an enabled transition sets the flag
  p_hit_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> flag_o);

  // R2: without an enabled transition a clear flag stays clear
  p_quiet_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_o && !flag_o) |=> !flag_o);

  // R4: acknowledge clears the flag
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !hit_o) |=> !flag_o);

  // R5: write-one clear clears the flag
  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && !hit_o) |=> !flag_o);

  // R5: with no clear request a set flag stays set
  p_flag_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_wr_i && !ack_i) |=> flag_o);

  // R8: a transition wins over a same-cycle clear
  p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && (clr_wr_i || ack_i)) |=> flag_o);

  if (PINS < REG_W) begin : g_pad_chk
    // R7: unused mask bits read as zero
    always_comb begin
      if (rst_n) begin
        p_mask_upper_zero_r7: assert (mask_o[REG_W-1:PINS] == '0);
      end
    end
  end

endmodule

// File: rtl/pcint_ctrl.sv
module pcint_ctrl #(
  parameter int G0_PINS = 8,
  parameter int G1_PINS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [G0_PINS+G1_PINS-1:0]    pin_in,
  input  logic                          gie,
  input  logic [1:0]                    ack,
  input  logic                          wr_en,
  input  logic [pcint_pkg::ADDR_W-1:0]  wr_addr,
  input  logic [pcint_pkg::REG_W-1:0]   wr_data,
  input  logic [pcint_pkg::ADDR_W-1:0]  rd_addr,
  output logic [pcint_pkg::REG_W-1:0]   rd_data,
  output logic [1:0]                    irq
);
  import pcint_pkg::*;

  localparam int TOTAL = G0_PINS + G1_PINS;
  localparam int GN    = NUM_GROUPS;

  logic [TOTAL-1:0] chg;
  logic [GN-1:0]    en_q;
  logic [GN-1:0]    flag;
  logic [GN-1:0]    hit;
  logic [GN-1:0]    mask_we;
  logic [GN-1:0]    clr_wr;
  logic [REG_W-1:0] mask_rd [GN];
  logic             ctrl_we;
  logic             flag_we;

  pcint_sync #(.W(TOTAL)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (pin_in),
    .chg_o (chg)
  );

  assign ctrl_we = wr_en && (wr_addr == ADR_CTRL);
  assign flag_we = wr_en && (wr_addr == ADR_FLAG);

  for (genvar g = 0; g < GN; g++) begin : g_grp
    localparam int PINS = (g == 0) ? G0_PINS : G1_PINS;
    localparam int BASE = (g == 0) ? 0 : G0_PINS;

    assign mask_we[g] = wr_en && (wr_addr == ADDR_W'(g));
    assign clr_wr[g]  = flag_we && wr_data[g];

    pcint_group #(.PINS(PINS), .REG_W(REG_W)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .chg_i     (chg[BASE +: PINS]),
      .mask_we_i (mask_we[g]),
      .wdata_i   (wr_data),
      .clr_wr_i  (clr_wr[g]),
      .ack_i     (ack[g]),
      .mask_o    (mask_rd[g]),
      .flag_o    (flag[g]),
      .hit_o     (hit[g])
    );

    assign irq[g] = req_gate(flag[g], en_q[g], gie);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (ctrl_we) begin
      en_q <= wr_data[GN-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_MASK0: rd_data = mask_rd[0];
      ADR_MASK1: rd_data = mask_rd[1];
      ADR_CTRL:  rd_data[GN-1:0] = en_q;
      ADR_FLAG:  rd_data[GN-1:0] = flag;
      default:   rd_data = '0;
    endcase
  end

  // R3: no request while the global enable is low
  p_no_irq_without_gie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq == '0));

  // R3: no request while the group enable is low
  p_no_irq_without_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (irq == '0));

  // R4: an acknowledged group drops its request unless a new hit arrives
  p_ack_drops_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && !hit[0]) |=> !irq[0]);

endmodule

// File: tb/tb_pcint_ctrl.sv
module tb_pcint_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pin_in = '0;
  logic        gie = 1'b0;
  logic [1:0]  ack = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [1:0]  irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pcint_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .gie(gie), .ack(ack),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // {mask0[8], mask1[8], pins[12], expected flags[2]}
  localparam int NV = 10;
  localparam logic [29:0] VEC [NV] = '{
    {8'h01, 8'h00, 12'h001, 2'b01},  // R1 rise line 0
    {8'h01, 8'h00, 12'h000, 2'b01},  // R1 fall line 0
    {8'hFE, 8'h00, 12'h001, 2'b00},  // R2 line 0 masked off
    {8'h00, 8'h01, 12'h101, 2'b10},  // R7 line 8 in group 1
    {8'h00, 8'h08, 12'h901, 2'b10},  // R7 line 11 in group 1
    {8'h80, 8'h00, 12'h981, 2'b01},  // R7 line 7 in group 0
    {8'hFF, 8'h0F, 12'h000, 2'b11},  // R1 falls in both groups
    {8'h00, 8'h00, 12'hFFF, 2'b00},  // R2 all masked off
    {8'h10, 8'h02, 12'hDEF, 2'b11},  // R1 lines 4 and 9
    {8'h10, 8'h00, 12'hDFF, 2'b01}   // R2 only line 4 enabled
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    cyc(3);
    // R6: reset values
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R6 reset register", v, 8'h00);
    end
    check("R6 reset irq", {6'b0, irq}, 8'h00);
    rst_n = 1'b1;
    cyc(2);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VEC[i][29:22]);
      wr(2'd1, VEC[i][21:14]);
      cyc(4);
      wr(2'd3, 8'h03);
      pin_in = VEC[i][13:2];
      cyc(4);
      rd(2'd3, v);
      check($sformatf("R1/R2/R7 vector %0d flags", i), v, {6'b0, VEC[i][1:0]});
    end

    // R7: upper group 1 mask bits ignore writes
    wr(2'd1, 8'hFF);
    rd(2'd1, v);
    check("R7 group1 mask readback", v, 8'h0F);
    wr(2'd0, 8'hFF);
    rd(2'd0, v);
    check("R7 group0 mask readback", v, 8'hFF);

    // Set both flags: toggle line 0 and line 8
    wr(2'd3, 8'h03);
    pin_in = 12'h000;
    cyc(4);
    rd(2'd3, v);
    check("R1 both flags set", v, 8'h03);

    // R5: zero write no effect, one write clears
    wr(2'd3, 8'h00);
    rd(2'd3, v);
    check("R5 write zero keeps flags", v, 8'h03);
    wr(2'd3, 8'h01);
    rd(2'd3, v);
    check("R5 write one clears group 0 only", v, 8'h02);

    // R3: gating
    gie = 1'b1;
    wr(2'd2, 8'h00);
    check("R3 no irq with group disabled", {6'b0, irq}, 8'h00);
    wr(2'd2, 8'h03);
    gie = 1'b0;
    #1;
    check("R3 no irq with gie low", {6'b0, irq}, 8'h00);
    gie = 1'b1;
    #1;
    check("R3 irq group 1 raised", {6'b0, irq}, 8'h02);
    rd(2'd2, v);
    check("R3 control readback", v, 8'h03);

    // R4: acknowledge clears
    ack = 2'b10;
    @(negedge clk);
    ack = 2'b00;
    rd(2'd3, v);
    check("R4 ack clears flag", v, 8'h00);
    check("R4 irq dropped", {6'b0, irq}, 8'h00);

    // R9: latency of three edges
    pin_in = 12'h001;
    cyc(2);
    rd(2'd3, v);
    check("R9 flag not yet set", v, 8'h00);
    cyc(1);
    rd(2'd3, v);
    check("R9 flag set after third edge", v, 8'h01);
    check("R3 irq group 0 raised", {6'b0, irq}, 8'h01);

    // R8: write-one clear coincident with detected transition
    wr(2'd3, 8'h01);
    pin_in = 12'h000;
    cyc(1);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
    cyc(1);
    rd(2'd3, v);
    check("R8 pre-edge cycle flag clear", v, 8'h00);
    cyc(1);
    wr_en = 1'b0; wr_data = '0;
    rd(2'd3, v);
    check("R8 edge wins over write clear", v, 8'h01);

    // R8: acknowledge coincident with detected transition
    wr(2'd3, 8'h03);
    pin_in = 12'h100;
    cyc(2);
    ack = 2'b10;
    cyc(1);
    ack = 2'b00;
    rd(2'd3, v);
    check("R8 edge wins over ack", v, 8'h02);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule